// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with LRU Replacement

This block sits between a processor load/store port and a word-wide backing memory. It holds eight sets of two lines each. Every line holds four 32-bit words. A byte address is split into a tag, a set index, a word select and a byte offset. Both ways of the selected set are probed at once. A read that matches a valid line returns its word in the same cycle and makes no memory request.

A read that matches neither way fetches the whole four-word line from memory, one word per handshake. The line goes into a free way if the set has one. Otherwise it replaces the line that the set used least recently. Once the fill is done, the read completes as a hit.

Stores always go to memory as a single word write. A store that hits also updates the cached copy and counts as a use of that way. A store that misses leaves the cache untouched. The requester holds its request fields stable from assertion until completion.

Top module: `cache2w`

## Requirements
- R1: After reset every line is invalid and every set's LRU bit is 0. `cpu_done` and `mem_req` are low, and the first read of any set misses.
- R2: Address bits [31:7] are the tag, [6:4] the set, [3:2] the word within the line and [1:0] the byte, which does not affect lookup or data returned.
- R3: A read hits when a valid way of the indexed set has an equal tag. It completes in the cycle it is presented, with no memory request, and returns that way's word. At most one way matches.
- R4: Two lines with the same set index and different tags can be resident together, and both then hit.
- R5: A read miss issues exactly four memory reads, in the order words 0, 1, 2, 3, at the line's address with bits [3:2] equal to the word number. The read then completes with the requested word.
- R6: A fill targets an invalid way if the set has one, way 0 before way 1.
- R7: When both ways are valid, a fill replaces the way the set's LRU bit names.
- R8: Each read hit, write hit and completed fill sets the LRU bit of that set to the way not just used.
- R9: Each store makes exactly one memory write (`mem_we`=1) carrying the store address and data. It completes in the cycle `mem_ready` is seen, with no memory read.
- R10: A store hit updates the cached word, so a later read hits and returns the new value. A store miss allocates nothing, so a later read of that line misses.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | Access completes at the next rising edge |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` on a load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for memory write, 0 for read |
| mem_addr | output | 32 | Memory byte address (word aligned on fills) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or returns the current word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The hardest case to reach is eviction in a full set whose LRU bit was last changed by a hit rather than by a fill. That case needs three distinct tags aimed at one set, with a hit on the older line placed between the fills. The bench walks every set through fill, fill, hit, third-tag miss and a re-read of the displaced tag. It then runs a long pseudo-random mix of loads and stores drawn from only six tags, so that conflicts stay dense. A reference model of valid bits, tags and LRU bits predicts the memory beats and the data of each access.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_STORE = 2'd2
   } ctrl_state_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
   parameter int TAG_W     = 25,
   parameter int SET_BITS  = 3,
   parameter int WORD_BITS = 2,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SET_BITS-1:0]  set_idx,
   input  logic [TAG_W-1:0]     tag_in,
   input  logic [WORD_BITS-1:0] rd_word,
   output logic                 hit,
   output logic                 line_valid,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 wr_en,
   input  logic [WORD_BITS-1:0] wr_word,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 install
);
   localparam int SETS  = 1 << SET_BITS;
   localparam int WORDS = 1 << WORD_BITS;

   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS][WORDS];

   assign line_valid = valid_q[set_idx];
   assign hit        = line_valid && (tag_q[set_idx] == tag_in);
   assign rd_data    = data_q[set_idx][rd_word];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (install) begin
         valid_q[set_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (install) begin
         tag_q[set_idx] <= tag_in;
      end
      if (wr_en) begin
         data_q[set_idx][wr_word] <= wr_data;
      end
   end

   // R4: a resident line stays valid; nothing but reset clears a valid bit
   a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(valid_q) & ~valid_q)) == '0));

   // R5: an installed line is valid on the following cycle
   a_r5_install_valid: assert property (@(posedge clk) disable iff (!rst_n)
      install |=> ($countones(valid_q) >= 1));
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
   parameter int SET_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SET_BITS-1:0] set_idx,
   input  logic [1:0]          valid_vec,
   input  logic                use_en,
   input  logic                used_way,
   output logic                victim
);
   localparam int SETS = 1 << SET_BITS;

   logic [SETS-1:0] lru_q;

   always_comb begin
      if (!valid_vec[0])      victim = 1'b0;
      else if (!valid_vec[1]) victim = 1'b1;
      else                    victim = lru_q[set_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lru_q <= '0;
      end else if (use_en) begin
         lru_q[set_idx] <= ~used_way;
      end
   end

   logic                chk_vld;
   logic [SET_BITS-1:0] chk_set;
   logic                chk_way;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld <= 1'b0;
         chk_set <= '0;
         chk_way <= 1'b0;
      end else begin
         chk_vld <= use_en;
         chk_set <= set_idx;
         chk_way <= used_way;
      end
   end

   // R8: after a use the set's LRU bit names the other way
   a_r8_lru_away: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld |-> (lru_q[chk_set] != chk_way));

   // R6: a set with a free way never chooses a valid way
   a_r6_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_vec != 2'b11) |-> !valid_vec[victim]);
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
   import cache2w_pkg::*;
#(
   parameter int WORD_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic                 any_hit,
   input  logic                 mem_ready,
   input  logic                 victim_in,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic                 in_fill,
   output logic                 fill_beat,
   output logic                 fill_last,
   output logic                 store_beat,
   output logic                 rd_done,
   output logic                 cpu_done,
   output logic [WORD_BITS-1:0] fill_cnt,
   output logic                 victim_q
);
   ctrl_state_e state_q;

   assign in_fill    = (state_q == ST_FILL);
   assign mem_req    = in_fill || (state_q == ST_STORE);
   assign mem_we     = (state_q == ST_STORE);
   assign fill_beat  = in_fill && mem_ready;
   assign fill_last  = fill_beat && (fill_cnt == '1);
   assign store_beat = (state_q == ST_STORE) && mem_ready;
   assign rd_done    = (state_q == ST_IDLE) && cpu_req && !cpu_we && any_hit;
   assign cpu_done   = rd_done || store_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         fill_cnt <= '0;
         victim_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req && cpu_we) begin
                  state_q <= ST_STORE;
               end else if (cpu_req && !any_hit) begin
                  state_q  <= ST_FILL;
                  fill_cnt <= '0;
                  victim_q <= victim_in;
               end
            end
            ST_FILL: begin
               if (mem_ready) begin
                  fill_cnt <= fill_cnt + 1'b1;
                  if (fill_cnt == '1) state_q <= ST_IDLE;
               end
            end
            ST_STORE: begin
               if (mem_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R11: a pending transfer keeps its direction and beat number
   a_r11_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(fill_cnt)));

   // R9: a store is a single memory beat
   a_r9_single_store: assert property (@(posedge clk) disable iff (!rst_n)
      store_beat |=> !mem_req);

   // R5: nothing completes while a line is being filled
   a_r5_no_done_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      in_fill |-> !cpu_done);

   // R5: the last fill beat returns to idle
   a_r5_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
      fill_last |=> !mem_req);
endmodule

// File: rtl/cache2w.sv
module cache2w #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SET_BITS  = 3,
   parameter int WORD_BITS = 2,
   parameter int WAYS      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int BYTE_BITS = $clog2(DATA_W / 8);
   localparam int WORD_LSB  = BYTE_BITS;
   localparam int SET_LSB   = WORD_LSB + WORD_BITS;
   localparam int TAG_LSB   = SET_LSB + SET_BITS;
   localparam int TAG_W     = ADDR_W - TAG_LSB;

   generate
      if (WAYS != 2) begin : g_bad_ways
         $error("cache2w: a single LRU bit per set supports exactly two ways");
      end
      if ((DATA_W % 8) != 0 || (1 << BYTE_BITS) * 8 != DATA_W) begin : g_bad_data
         $error("cache2w: DATA_W must be a power-of-two number of bytes");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("cache2w: address too narrow for the chosen geometry");
      end
   endgenerate

   logic [TAG_W-1:0]     tag_f;
   logic [SET_BITS-1:0]  set_f;
   logic [WORD_BITS-1:0] word_f;

   assign tag_f  = cpu_addr[TAG_LSB +: TAG_W];
   assign set_f  = cpu_addr[SET_LSB +: SET_BITS];
   assign word_f = cpu_addr[WORD_LSB +: WORD_BITS];

   logic [WAYS-1:0]   hit_vec;
   logic [WAYS-1:0]   valid_vec;
   logic [DATA_W-1:0] way_rdata [WAYS];
   logic              any_hit;
   logic              hit_way;

   logic                 in_fill, fill_beat, fill_last, store_beat, rd_done;
   logic [WORD_BITS-1:0] fill_cnt;
   logic                 victim_c, victim_q;

   logic [WORD_BITS-1:0] wr_word;
   logic [DATA_W-1:0]    wr_data;

   assign wr_word = in_fill ? fill_cnt  : word_f;
   assign wr_data = in_fill ? mem_rdata : cpu_wdata;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic way_wr, way_install;
         assign way_wr      = (fill_beat && (victim_q == 1'(w))) || (store_beat && hit_vec[w]);
         assign way_install = fill_last && (victim_q == 1'(w));

         cache2w_way #(
            .TAG_W(TAG_W), .SET_BITS(SET_BITS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W)
         ) u_way (
            .clk(clk), .rst_n(rst_n),
            .set_idx(set_f), .tag_in(tag_f), .rd_word(word_f),
            .hit(hit_vec[w]), .line_valid(valid_vec[w]), .rd_data(way_rdata[w]),
            .wr_en(way_wr), .wr_word(wr_word), .wr_data(wr_data),
            .install(way_install)
         );
      end
   endgenerate

   assign any_hit = |hit_vec;

   always_comb begin
      cpu_rdata = '0;
      hit_way   = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            cpu_rdata = cpu_rdata | way_rdata[w];
            hit_way   = 1'(w);
         end
      end
   end

   logic lru_use, lru_way;
   assign lru_use = rd_done || (store_beat && any_hit) || fill_last;
   assign lru_way = fill_last ? victim_q : hit_way;

   cache2w_lru #(.SET_BITS(SET_BITS)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .set_idx(set_f), .valid_vec(valid_vec),
      .use_en(lru_use), .used_way(lru_way),
      .victim(victim_c)
   );

   cache2w_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .any_hit(any_hit),
      .mem_ready(mem_ready), .victim_in(victim_c),
      .mem_req(mem_req), .mem_we(mem_we),
      .in_fill(in_fill), .fill_beat(fill_beat), .fill_last(fill_last),
      .store_beat(store_beat), .rd_done(rd_done), .cpu_done(cpu_done),
      .fill_cnt(fill_cnt), .victim_q(victim_q)
   );

   assign mem_addr  = in_fill ? {tag_f, set_f, fill_cnt, {BYTE_BITS{1'b0}}} : cpu_addr;
   assign mem_wdata = cpu_wdata;

   // R3: tags in one set never match twice
   a_r3_one_way_hits: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R3: a read hit needs no memory transfer
   a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !mem_req);

   // R11: address and data hold while memory has not answered
   a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

   // R6: the line chosen at the start of a fill stays the target
   a_r6_victim_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fill && !fill_last) |=> $stable(victim_q));
endmodule

// File: tb/cache2w_test.sv
module cache2w_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #10 clk = ~clk;

   cache2w uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [4096];
   int  rd_beats = 0, wr_beats = 0, lat = 0;
   bit  order_bad = 0, hold_bad = 0, prev_wait = 0;
   logic [31:0] prev_addr = '0, prev_wdata = '0;
   logic        prev_we = 1'b0;

   int  m_tag [8][2];
   bit  m_val [8][2];
   bit  m_lru [8];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory responder: answers after two idle cycles
   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      forever begin
         @(negedge clk);
         if (mem_req && prev_wait &&
             (mem_addr !== prev_addr || mem_we !== prev_we || (mem_we && mem_wdata !== prev_wdata)))
            hold_bad = 1;
         if (mem_req && lat >= 2) begin
            mem_ready = 1'b1;
            lat = 0;
            if (mem_we) begin
               mem[mem_addr[13:2]] = mem_wdata;
               wr_beats++;
            end else begin
               if (mem_addr[3:2] != rd_beats[1:0] || mem_addr[31:4] != cpu_addr[31:4] ||
                   mem_addr[1:0] != 2'b00)
                  order_bad = 1;
               mem_rdata = mem[mem_addr[13:2]];
               rd_beats++;
            end
         end else begin
            mem_ready = 1'b0;
            if (mem_req) lat++;
            else lat = 0;
         end
         prev_wait  = mem_req && !mem_ready;
         prev_addr  = mem_addr;
         prev_we    = mem_we;
         prev_wdata = mem_wdata;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic run_access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                             output logic [31:0] rdata);
      @(negedge clk);
      rd_beats = 0; wr_beats = 0; order_bad = 0; hold_bad = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      #2;
      while (!cpu_done) begin
         @(negedge clk);
         #2;
      end
      rdata = cpu_rdata;
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
   endtask

   function automatic logic [31:0] mk(input int tag, input int set, input int word, input int byt);
      return {18'd0, 7'(tag), 3'(set), 2'(word), 2'(byt)};
   endfunction

   task automatic model_lookup(input int set, input int tag, output bit hit, output int way);
      hit = 0; way = 0;
      for (int w = 0; w < 2; w++)
         if (m_val[set][w] && m_tag[set][w] == tag) begin hit = 1; way = w; end
   endtask

   task automatic do_read(input int tag, input int set, input int word, input int byt, input string req);
      bit hit; int way; logic [31:0] rd, addr, exp;
      addr = mk(tag, set, word, byt);
      model_lookup(set, tag, hit, way);
      exp = mem[addr[13:2]];
      run_access(1'b0, addr, '0, rd);
      check(rd_beats == (hit ? 0 : 4), {req, " read beats"}, rd_beats, hit ? 0 : 4);
      check(rd == exp, {req, " read data"}, rd, exp);
      check(!order_bad, "R5 fill order/address", {31'd0, order_bad}, 0);
      check(!hold_bad, "R11 transfer hold", {31'd0, hold_bad}, 0);
      if (hit) m_lru[set] = ~way[0];
      else begin
         if (!m_val[set][0]) way = 0;
         else if (!m_val[set][1]) way = 1;
         else way = m_lru[set];
         m_val[set][way] = 1; m_tag[set][way] = tag; m_lru[set] = ~way[0];
      end
   endtask

   task automatic do_write(input int tag, input int set, input int word, input logic [31:0] wd);
      bit hit; int way; logic [31:0] rd, addr;
      addr = mk(tag, set, word, 0);
      model_lookup(set, tag, hit, way);
      run_access(1'b1, addr, wd, rd);
      check(rd_beats == 0 && wr_beats == 1, "R9 one write beat", rd_beats * 16 + wr_beats, 1);
      check(mem[addr[13:2]] == wd, "R9 memory updated", mem[addr[13:2]], wd);
      check(!hold_bad, "R11 store hold", {31'd0, hold_bad}, 0);
      if (hit) m_lru[set] = ~way[0];
   endtask

   initial begin
      int seed;
      for (int s = 0; s < 8; s++) begin
         m_lru[s] = 0;
         for (int w = 0; w < 2; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; end
      end
      repeat (3) @(posedge clk);
      #3;
      check(cpu_done == 1'b0, "R1 done low after reset", {31'd0, cpu_done}, 0);
      check(mem_req == 1'b0, "R1 no request after reset", {31'd0, mem_req}, 0);
      rst_n = 1'b1;

      for (int s = 0; s < 8; s++) begin
         do_read(1, s, s % 4, 0, "R1 R5 cold miss");
         do_read(1, s, (s + 1) % 4, 3, "R2 R3 hit other word, byte ignored");
         do_read(2, s, 2, 1, "R6 fill free way");
         do_read(1, s, 0, 2, "R4 first line still hits");
         do_read(2, s, 3, 0, "R4 second line hits");
         do_read(1, s, 1, 0, "R8 hit updates LRU");
         do_read(3, s, 0, 0, "R7 evict least recent");
         do_read(1, s, 2, 0, "R7 protected line hits");
         do_read(2, s, 1, 0, "R7 evicted line misses");
         do_read(3, s, 3, 0, "R8 fill updates LRU");
      end

      for (int s = 0; s < 8; s++) begin
         do_write(3, s, 1, 32'hC0DE_0000 + s);
         do_read(3, s, 1, 0, "R10 store hit visible");
         do_write(9, s, 2, 32'hBEEF_0000 + s);
         do_read(9, s, 2, 0, "R10 store miss not allocated");
      end

      seed = 7;
      for (int n = 0; n < 800; n++) begin
         int tg, st, wd;
         seed = seed * 1103515245 + 12345;
         tg = (seed >>> 8) & 7; if (tg > 5) tg = tg - 6;
         st = (seed >>> 12) & 7;
         wd = (seed >>> 16) & 3;
         if (((seed >>> 20) & 3) == 0) do_write(tg + 10, st, wd, seed);
         else do_read(tg + 10, st, wd, (seed >>> 24) & 3, "R3 R7 R8 sweep");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule